// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block runs the source side of DisplayPort link training over one, two or four lanes. A single start pulse makes it configure the sink first: it powers the sink up, sets downspread, sets the lane count with the enhanced-framing bit, and sets the link-rate code. It then runs clock recovery, followed by channel equalisation. During both phases it drives the training pattern and the per-lane drive settings to the transmitter. It also fetches sink status, and it turns the adjustment requests from the sink into new drive settings.

Every sink access goes through an abstract request/response port that carries an operation code and a data word. Microsecond waits are counted on a one-cycle `us_tick` strobe. On every outcome, the sequence ends by switching the training pattern off, and then gives a one-cycle pass or fail pulse. The configuration inputs must be held steady while `busy` is high.

Top module: `dp_train_seq`

## Requirements
- R1: `start` in idle raises `busy`, which stays high until the cycle that carries the pass or fail pulse, where it drops. A `start` while busy is ignored and does not restart the configuration writes.
- R2: Configuration issues four writes in this order, one request at a time, each waiting for its response: op 0 power-up (data 1), op 1 downspread (0x10 if enabled, else 0), op 2 lane count (count, plus 0x80 when enhanced framing is on), op 3 link-rate code.
- R3: Clock recovery sets pattern 1 (op 4, data 1) on `tp_sel` and at the sink, then writes all-zero lane settings (op 5, byte i for lane i). It waits SETTLE_US ticks. Before each status read (op 6) it waits `sink_delay_us` ticks.
- R4: The status response carries per-lane clock-recovery flags in bits 3:0, equalisation flags in bits 7:4, and a 4-bit adjust request per lane at bits 8+4i (swing 1:0, pre-emphasis 3:2). Clock recovery passes when every active lane reports its flag.
- R5: Clock recovery fails if every active lane's current setting already carries the max-swing flag.
- R6: A counter tracks repeats of lane 0's swing against the previous iteration. The stored previous value starts as one that no swing can match. The counter resets when the swing differs. Clock recovery fails when the counter would reach 5.
- R7: A new setting byte takes the highest swing and the highest pre-emphasis requested by the active lanes; inactive lanes are ignored. Its layout is swing 1:0, max-swing flag 2 (swing is 3), pre-emphasis 4:3, max-pre flag 5 (pre-emphasis is 3). The same byte goes to all four lanes.
- R8: Equalisation uses pattern 3 when `tp3_supported` is set and pattern 2 otherwise. It passes when all active lanes report both the clock-recovery and equalisation flags.
- R9: The equalisation try counter rises after each adjustment. The phase fails on the read after the counter exceeds 5, which is seven equalisation reads in all.
- R10: A status read whose response has `resp_err` set ends training as a failure in either phase.
- R11: On pass and on fail alike, the block waits SETTLE_US ticks after the last status read. It then sets the pattern to off (op 4, data 0) on `tp_sel` and at the sink, and only then pulses pass or fail. The two are never pulsed together.
- R12: After reset `busy`, `pass`, `fail`, `req_valid`, `tp_sel` and `lane_cfg` are all zero, including when reset hits in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin training (accepted only when idle) |
| lane_count | input | 3 | Active lanes: 1, 2 or 4 |
| link_rate | input | 8 | Link-rate code written to the sink |
| downspread_en | input | 1 | Sink supports downspread |
| enh_frame_en | input | 1 | Sink supports enhanced framing |
| tp3_supported | input | 1 | Pattern 3 usable for equalisation |
| sink_delay_us | input | 16 | Sink-specified wait before each status read |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| req_valid | output | 1 | One-cycle sink access request |
| req_op | output | 3 | Operation code (0..6) |
| req_data | output | 32 | Write data; lane settings as four bytes |
| resp_valid | input | 1 | Response to the outstanding request |
| resp_err | input | 1 | Access failed (acted on only for status reads) |
| resp_data | input | 24 | Status: flags and adjust requests |
| tp_sel | output | 2 | Training pattern to the transmitter (0 off) |
| lane_cfg | output | 32 | Drive setting byte per lane |
| busy | output | 1 | Training in progress |
| pass | output | 1 | One-cycle training success |
| fail | output | 1 | One-cycle training failure |

## Verification
If the counters or the stored previous swing go wrong, the number of status reads before the result changes. The bench counts these reads per run, so the error shows up no later than the pulse that ends that run. A wrong lane-mask or max-selection state shows in the `lane_cfg` bytes and in the lane-setting writes at the first adjustment, one status read after the sink asks for it. A sequencing fault shows up in the order of the request log or in the tick spacing between writes. Examples are a skipped settle wait, a pattern left on, or a result pulsed before the pattern-off write.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  typedef enum logic [2:0] {
    OP_POWER   = 3'd0,
    OP_SPREAD  = 3'd1,
    OP_LANECNT = 3'd2,
    OP_RATE    = 3'd3,
    OP_PATTERN = 3'd4,
    OP_LANESET = 3'd5,
    OP_STATUS  = 3'd6
  } op_e;

  typedef enum logic [4:0] {
    S_IDLE, S_PWR, S_SPREAD, S_LCNT, S_RATE,
    S_CR_PAT, S_CR_LANES, S_CR_SETTLE, S_CR_WAIT, S_CR_READ, S_CR_APPLY,
    S_EQ_PAT, S_EQ_WAIT, S_EQ_READ, S_EQ_APPLY,
    S_FIN_WAIT, S_FIN_PAT
  } st_e;
endpackage

// File: rtl/dpt_us_timer.sv
module dpt_us_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt)); // R3
endmodule

// File: rtl/dpt_lane_mask.sv
module dpt_lane_mask #(
  parameter int LANES = 4,
  parameter int CW    = 3
) (
  input  logic [CW-1:0]    lane_count,
  output logic [LANES-1:0] active
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign active[i] = (lane_count > CW'(i));
  end
endmodule

// File: rtl/dpt_lane_adjust.sv
module dpt_lane_adjust #(
  parameter int LANES = 4
) (
  input  logic [4*LANES-1:0] adj_req,
  input  logic [LANES-1:0]   active,
  output logic [7:0]         set_byte
);
  logic [1:0] v_max, p_max;

  always_comb begin
    v_max = 2'd0;
    p_max = 2'd0;
    for (int i = 0; i < LANES; i++) begin
      if (active[i]) begin
        if (adj_req[4*i +: 2] > v_max)     v_max = adj_req[4*i +: 2];
        if (adj_req[4*i + 2 +: 2] > p_max) p_max = adj_req[4*i + 2 +: 2];
      end
    end
    set_byte = {2'b00, (p_max == 2'd3), p_max, (v_max == 2'd3), v_max};
  end
endmodule

// File: rtl/dp_train_seq.sv
module dp_train_seq
  import dpt_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int DLY_W       = 16,
  parameter int SETTLE_US   = 400,
  parameter int CR_SAME_MAX = 5,
  parameter int EQ_TRY_MAX  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [2:0]           lane_count,
  input  logic [7:0]           link_rate,
  input  logic                 downspread_en,
  input  logic                 enh_frame_en,
  input  logic                 tp3_supported,
  input  logic [DLY_W-1:0]     sink_delay_us,
  input  logic                 us_tick,
  output logic                 req_valid,
  output logic [2:0]           req_op,
  output logic [8*LANES-1:0]   req_data,
  input  logic                 resp_valid,
  input  logic                 resp_err,
  input  logic [6*LANES-1:0]   resp_data,
  output logic [1:0]           tp_sel,
  output logic [8*LANES-1:0]   lane_cfg,
  output logic                 busy,
  output logic                 pass,
  output logic                 fail
);
  localparam int SET_W = 8 * LANES;
  localparam int CRW   = $clog2(CR_SAME_MAX + 1);
  localparam int EQW   = $clog2(EQ_TRY_MAX + 2);

  st_e              state;
  logic             sent, ok;
  logic [SET_W-1:0] lane_set;
  logic [2:0]       prev_v;
  logic [CRW-1:0]   cr_same;
  logic [EQW-1:0]   eq_try;

  logic [LANES-1:0] active, st_cr, st_eq, max_flag;
  logic             all_cr, all_eq, all_max, v_same, is_wait, tmr_load, tmr_exp;
  logic [7:0]       adj_byte;
  op_e              c_op;
  logic [SET_W-1:0] c_data;
  logic [DLY_W-1:0] tmr_val;

  assign st_cr = resp_data[LANES-1:0];
  assign st_eq = resp_data[2*LANES-1:LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_flag
    assign max_flag[i] = lane_set[8*i + 2];
  end

  assign all_cr  = &(st_cr | ~active);
  assign all_eq  = &(st_eq | ~active);
  assign all_max = &(max_flag | ~active);
  assign v_same  = ({1'b0, lane_set[1:0]} == prev_v);

  dpt_lane_mask #(.LANES(LANES), .CW(3)) mask_i (
    .lane_count(lane_count), .active(active));

  dpt_lane_adjust #(.LANES(LANES)) adj_i (
    .adj_req(resp_data[6*LANES-1:2*LANES]), .active(active), .set_byte(adj_byte));

  assign is_wait  = (state == S_CR_SETTLE) || (state == S_CR_WAIT) ||
                    (state == S_EQ_WAIT)   || (state == S_FIN_WAIT);
  assign tmr_load = is_wait && !sent;
  assign tmr_val  = ((state == S_CR_SETTLE) || (state == S_FIN_WAIT)) ?
                    DLY_W'(SETTLE_US) : sink_delay_us;

  dpt_us_timer #(.W(DLY_W)) tmr_i (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .tick(us_tick), .expired(tmr_exp));

  always_comb begin
    c_op   = OP_STATUS;
    c_data = '0;
    case (state)
      S_PWR:      begin c_op = OP_POWER;   c_data = SET_W'(1); end
      S_SPREAD:   begin c_op = OP_SPREAD;  c_data = SET_W'(downspread_en ? 8'h10 : 8'h00); end
      S_LCNT:     begin c_op = OP_LANECNT; c_data = SET_W'({enh_frame_en, 4'b0000, lane_count}); end
      S_RATE:     begin c_op = OP_RATE;    c_data = SET_W'(link_rate); end
      S_CR_PAT:   begin c_op = OP_PATTERN; c_data = SET_W'(1); end
      S_EQ_PAT:   begin c_op = OP_PATTERN; c_data = SET_W'(tp3_supported ? 2'd3 : 2'd2); end
      S_FIN_PAT:  begin c_op = OP_PATTERN; c_data = '0; end
      S_CR_LANES, S_CR_APPLY, S_EQ_APPLY:
                  begin c_op = OP_LANESET; c_data = lane_set; end
      default:    begin c_op = OP_STATUS;  c_data = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      sent      <= 1'b0;
      ok        <= 1'b0;
      req_valid <= 1'b0;
      req_op    <= 3'd0;
      req_data  <= '0;
      tp_sel    <= 2'd0;
      lane_set  <= '0;
      prev_v    <= 3'b100;
      cr_same   <= '0;
      eq_try    <= '0;
      busy      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          busy  <= 1'b1;
          state <= S_PWR;
        end
      end else if (!sent) begin
        sent <= 1'b1;
        if (!is_wait) begin
          req_valid <= 1'b1;
          req_op    <= c_op;
          req_data  <= c_data;
          if (c_op == OP_PATTERN) tp_sel <= c_data[1:0];
        end
      end else if (is_wait ? tmr_exp : resp_valid) begin
        sent <= 1'b0;
        case (state)
          S_PWR:       state <= S_SPREAD;
          S_SPREAD:    state <= S_LCNT;
          S_LCNT:      state <= S_RATE;
          S_RATE: begin
            lane_set <= '0;
            prev_v   <= 3'b100;
            cr_same  <= '0;
            state    <= S_CR_PAT;
          end
          S_CR_PAT:    state <= S_CR_LANES;
          S_CR_LANES:  state <= S_CR_SETTLE;
          S_CR_SETTLE: state <= S_CR_WAIT;
          S_CR_WAIT:   state <= S_CR_READ;
          S_CR_READ: begin
            if (resp_err) begin
              ok <= 1'b0; state <= S_FIN_WAIT;
            end else if (all_cr) begin
              state <= S_EQ_PAT;
            end else if (all_max || (v_same && cr_same == CRW'(CR_SAME_MAX - 1))) begin
              ok <= 1'b0; state <= S_FIN_WAIT;
            end else begin
              cr_same  <= v_same ? cr_same + 1'b1 : '0;
              prev_v   <= {1'b0, lane_set[1:0]};
              lane_set <= {LANES{adj_byte}};
              state    <= S_CR_APPLY;
            end
          end
          S_CR_APPLY:  state <= S_CR_WAIT;
          S_EQ_PAT: begin
            eq_try <= '0;
            state  <= S_EQ_WAIT;
          end
          S_EQ_WAIT:   state <= S_EQ_READ;
          S_EQ_READ: begin
            if (resp_err) begin
              ok <= 1'b0; state <= S_FIN_WAIT;
            end else if (all_cr && all_eq) begin
              ok <= 1'b1; state <= S_FIN_WAIT;
            end else if (eq_try > EQW'(EQ_TRY_MAX)) begin
              ok <= 1'b0; state <= S_FIN_WAIT;
            end else begin
              lane_set <= {LANES{adj_byte}};
              eq_try   <= eq_try + 1'b1;
              state    <= S_EQ_APPLY;
            end
          end
          S_EQ_APPLY:  state <= S_EQ_WAIT;
          S_FIN_WAIT:  state <= S_FIN_PAT;
          S_FIN_PAT: begin
            pass  <= ok;
            fail  <= !ok;
            busy  <= 1'b0;
            state <= S_IDLE;
          end
          default:     state <= S_IDLE;
        endcase
      end
    end
  end

  assign lane_cfg = lane_set;

  logic lanes_same;
  always_comb begin
    lanes_same = 1'b1;
    for (int i = 1; i < LANES; i++)
      if (lane_set[8*i +: 8] != lane_set[7:0]) lanes_same = 1'b0;
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail)); // R11
  AST_RESULT_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (pass || fail) |-> (!busy && $past(busy))); // R1
  AST_PATTERN_OFF: assert property (@(posedge clk) disable iff (rst)
    (pass || fail) |-> (tp_sel == 2'd0)); // R11
  AST_LANES_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    lanes_same); // R7
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid); // R1
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid); // R2
  AST_CR_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cr_same < CRW'(CR_SAME_MAX)); // R6
endmodule

// File: tb/dp_train_seq_tb.sv
`timescale 1ns/1ps
module dp_train_seq_tb_top;
  localparam int SETTLE = 400;
  localparam int DELAY  = 3;
  localparam int WD_LIMIT = 150000;

  typedef struct packed {
    logic [2:0]  lanes;
    logic        tp3;
    logic [3:0]  cr_at;
    logic [3:0]  eq_at;
    logic [3:0]  err_at;
    logic [15:0] adj;
    logic        exp_pass;
    logic [3:0]  exp_reads;
    logic [7:0]  exp_lane0;
    logic [1:0]  exp_lastpat;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 1'b0, 4'd0,  4'd1,  4'd15, 16'h0000, 1'b1, 4'd2, 8'h00, 2'd2}, // R4 R8 quick pass
    '{3'd2, 1'b1, 4'd2,  4'd4,  4'd15, 16'hFF61, 1'b1, 4'd5, 8'h0A, 2'd3}, // R7 R8 tp3, inactive ignored
    '{3'd1, 1'b0, 4'd15, 4'd15, 4'd15, 16'hF0F3, 1'b0, 4'd2, 8'h07, 2'd1}, // R5 max swing
    '{3'd4, 1'b0, 4'd15, 4'd15, 4'd15, 16'h0000, 1'b0, 4'd6, 8'h00, 2'd1}, // R6 same swing
    '{3'd2, 1'b0, 4'd0,  4'd15, 4'd15, 16'h00C9, 1'b0, 4'd8, 8'h39, 2'd2}, // R9 eq exhaustion
    '{3'd4, 1'b0, 4'd15, 4'd15, 4'd0,  16'h0000, 1'b0, 4'd1, 8'h00, 2'd1}, // R10 error in CR
    '{3'd1, 1'b1, 4'd0,  4'd15, 4'd2,  16'h0005, 1'b0, 4'd3, 8'h09, 2'd3}, // R10 error in EQ
    '{3'd4, 1'b0, 4'd1,  4'd2,  4'd15, 16'hE000, 1'b1, 4'd3, 8'h3A, 2'd2}  // R7 lane 3 drives
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  lane_count = 3'd4;
  logic [7:0]  link_rate = 8'h0A;
  logic        downspread_en = 1'b0;
  logic        enh_frame_en = 1'b0;
  logic        tp3_supported = 1'b0;
  logic [15:0] sink_delay_us = 16'(DELAY);
  logic        us_tick = 1'b1;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [31:0] req_data;
  logic        resp_valid = 1'b0;
  logic        resp_err = 1'b0;
  logic [23:0] resp_data = '0;
  logic [1:0]  tp_sel;
  logic [31:0] lane_cfg;
  logic        busy, pass, fail;

  always #2.5 clk = ~clk;

  dp_train_seq #(.SETTLE_US(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .start(start), .lane_count(lane_count),
    .link_rate(link_rate), .downspread_en(downspread_en),
    .enh_frame_en(enh_frame_en), .tp3_supported(tp3_supported),
    .sink_delay_us(sink_delay_us), .us_tick(us_tick),
    .req_valid(req_valid), .req_op(req_op), .req_data(req_data),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_data(resp_data),
    .tp_sel(tp_sel), .lane_cfg(lane_cfg), .busy(busy), .pass(pass), .fail(fail));

  integer n_chk = 0, n_fail = 0, cyc = 0;
  integer rsp_pend = 0;
  logic        p_err;
  logic [23:0] p_data;
  vec_t        cur;
  logic [31:0] exp_init [4];
  integer n_reads, n_power, op_idx, t_lanes0, t_stat0, t_stat_last, t_fin;
  logic   init_ok, res_seen, res_pass, res_fail, res_busy, fin_after;
  logic [1:0]  last_nzpat, res_tp;
  logic [31:0] last_pat, res_lane;

  task automatic chk(input logic cond, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_reads = 0; n_power = 0; op_idx = 0; init_ok = 1'b1;
    t_lanes0 = -1; t_stat0 = -1; t_stat_last = -1; t_fin = -1;
    res_seen = 1'b0; res_pass = 1'b0; res_fail = 1'b0; res_busy = 1'b1;
    last_nzpat = 2'd0; last_pat = 32'hFFFF_FFFF; res_tp = 2'd3; res_lane = '0;
    fin_after = 1'b0;
  endtask

  // Sink model, request log and watchdog; everything sampled on the falling edge.
  always @(negedge clk) begin
    cyc++;
    resp_valid = 1'b0;
    if (rsp_pend > 0) begin
      rsp_pend--;
      if (rsp_pend == 0) begin
        resp_valid = 1'b1;
        resp_err   = p_err;
        resp_data  = p_data;
      end
    end
    if (req_valid && !rst) begin
      if (op_idx < 4 && (req_op != 3'(op_idx) || req_data != exp_init[op_idx])) init_ok = 1'b0;
      op_idx++;
      p_err = 1'b0;
      p_data = '0;
      case (req_op)
        3'd0: n_power++;
        3'd4: begin
          last_pat = req_data;
          if (req_data[1:0] != 2'd0) last_nzpat = req_data[1:0];
          else if (t_stat_last >= 0) begin t_fin = cyc; fin_after = 1'b1; end
        end
        3'd5: if (t_lanes0 < 0) t_lanes0 = cyc;
        3'd6: begin
          if (t_stat0 < 0) t_stat0 = cyc;
          t_stat_last = cyc;
          p_err  = (n_reads == int'(cur.err_at));
          p_data = {cur.adj,
                    (n_reads >= int'(cur.eq_at)) ? 4'hF : 4'h0,
                    (n_reads >= int'(cur.cr_at)) ? 4'hF : 4'h0};
          n_reads++;
        end
        default: ;
      endcase
      rsp_pend = 2;
    end
    if ((pass || fail) && !res_seen) begin
      res_seen = 1'b1; res_pass = pass; res_fail = fail; res_busy = busy;
      res_tp = tp_sel; res_lane = lane_cfg;
    end
    if (cyc > WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_vec(input int i, input logic double_start);
    cur = VECS[i];
    lane_count    = cur.lanes;
    tp3_supported = cur.tp3;
    downspread_en = i[0];
    enh_frame_en  = i[1];
    link_rate     = 8'h06 + 8'(i);
    exp_init[0] = 32'd1;
    exp_init[1] = i[0] ? 32'h10 : 32'h0;
    exp_init[2] = {24'd0, i[1], 4'd0, cur.lanes};
    exp_init[3] = {24'd0, 8'h06 + 8'(i)};
    clear_log();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R1 busy after start", 32'(busy), 1);
    if (double_start) begin
      repeat (10) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    for (int k = 0; k < 20000 && !res_seen; k++) @(negedge clk);
    chk(res_seen && res_pass == cur.exp_pass && res_fail == !cur.exp_pass,
        $sformatf("R4/R5/R6/R9/R10 vec %0d result", i), {res_pass, res_fail}, {cur.exp_pass, !cur.exp_pass});
    chk(res_busy == 1'b0, "R1 busy low with result", 32'(res_busy), 0);
    chk(n_reads == int'(cur.exp_reads), $sformatf("R6/R9 vec %0d status reads", i), n_reads, cur.exp_reads);
    chk(res_lane[7:0] == cur.exp_lane0, $sformatf("R7 vec %0d lane byte", i), res_lane[7:0], cur.exp_lane0);
    chk(res_lane == {4{res_lane[7:0]}}, "R7 same byte on all lanes", res_lane, {4{res_lane[7:0]}});
    chk(last_nzpat == cur.exp_lastpat, $sformatf("R8 vec %0d pattern", i), last_nzpat, cur.exp_lastpat);
    chk(init_ok && op_idx >= 4, "R2 configuration writes", op_idx, 4);
    chk(t_stat0 - t_lanes0 >= SETTLE + DELAY, "R3 settle before first read",
        t_stat0 - t_lanes0, SETTLE + DELAY);
    chk(fin_after && last_pat == 0 && res_tp == 2'd0 && t_fin - t_stat_last >= SETTLE,
        "R11 finish wait then pattern off", t_fin - t_stat_last, SETTLE);
    if (double_start) chk(n_power == 1, "R1 start ignored while busy", n_power, 1);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    clear_log();
    cur = VECS[0];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, pass, fail, req_valid} == 4'b0, "R12 reset controls", {busy, pass, fail, req_valid}, 0);
    chk(tp_sel == 2'd0 && lane_cfg == 32'd0, "R12 reset pattern and lanes", {tp_sel, lane_cfg[7:0]}, 0);

    for (int i = 0; i < NV; i++) run_vec(i, i == 0);

    // Reset in the middle of a run that has already applied non-zero settings
    cur = VECS[7];
    clear_log();
    lane_count = 3'd4; tp3_supported = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 3000 && t_stat0 < 0; k++) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(lane_cfg != 32'd0 && tp_sel == 2'd1, "R3 pattern 1 with adjusted lanes", {tp_sel, lane_cfg[7:0]}, 32'h13A);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rsp_pend = 0;
    rst = 1'b0;
    @(negedge clk);
    chk({busy, pass, fail, req_valid} == 4'b0, "R12 mid-run reset controls", {busy, pass, fail, req_valid}, 0);
    chk(tp_sel == 2'd0 && lane_cfg == 32'd0, "R12 mid-run reset outputs", {tp_sel, lane_cfg[7:0]}, 0);

    // A fresh run after the reset still passes
    run_vec(0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule